// File: doc/BRIEF.md
# Slow-Control Port Command Dispatcher

The dispatcher takes slow-control commands from a packet-level front end and routes each one to one of several user-side bus ports, such as a serial bus master, a parallel port or a memory bus. A command names the requester's source address, a target port number, an operation code (read or write), a register address and write data. Each port has exactly one command buffer. While that buffer is occupied, any further command to the same port is turned away at once with a busy reply and is not forwarded.

A port is modelled as a request/done handshake. The dispatcher holds the request until the port signals completion, then keeps the result in the port's buffer until a reply has been delivered. Replies leave through one valid/ready output. Every reply carries the source address that issued the command, the port number, a status code and read data. Several ports may finish in the same cycle or in any order. Pending replies, including the immediate busy and error replies, are taken in round-robin order. A port's buffer is released only when its reply has been accepted.

Top module: `sc_dispatch`

## Requirements
- R1: During and right after a synchronous reset, cmd_ready is 1, rpl_valid is 0 and every port_req bit is 0.
- R2: An accepted command whose op code is read (2'b01) or write (2'b10), aimed at an idle port below NPORT, raises port_req for that port from the next cycle. port_we is 1 for write and 0 for read, and port_addr and port_wdata carry the command's fields. All of these hold until the cycle in which port_done is sampled high.
- R3: An accepted valid command to a port whose buffer is occupied is not forwarded. It is answered with status 2'b01 (busy), carrying its own source address and port number.
- R4: An accepted command with port number at or above NPORT, or with op code 2'b00 or 2'b11, touches no port. It is answered with status 2'b10 (error), carrying its own source address and port number.
- R5: Every accepted command produces exactly one reply. A completed port operation is replied with status 2'b00 (acknowledge), the issuing source address and the port number.
- R6: Pending replies are arbitrated round-robin over requester indices 0 to NPORT-1 (the port buffers) and NPORT (the immediate busy/error reply). The search starts one index above the last one granted, and at index 0 after reset.
- R7: While rpl_valid is 1 and rpl_ready is 0, rpl_valid stays 1 and rpl_src, rpl_port, rpl_status and rpl_data stay unchanged in the next cycle.
- R8: A port buffer stays occupied after completion until its reply is accepted. A command to that port in the meantime gets the busy reply.
- R9: cmd_ready is 0 exactly while an immediate busy or error reply is waiting to be accepted.
- R10: rpl_data holds the port_rdata value sampled at completion for a read. For a write, busy or error reply it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_src | input | SRC_W | Source address of the requester |
| cmd_port | input | PORT_W | Target port number |
| cmd_op | input | 2 | Operation code: 01 read, 10 write |
| cmd_addr | input | ADDR_W | Register address inside the port |
| cmd_wdata | input | DATA_W | Write data |
| port_req | output | NPORT | Per-port request, held until done |
| port_we | output | NPORT | Per-port write enable |
| port_addr | output | NPORT*ADDR_W | Per-port register address, port i at slice i |
| port_wdata | output | NPORT*DATA_W | Per-port write data |
| port_done | input | NPORT | Per-port completion pulse |
| port_rdata | input | NPORT*DATA_W | Per-port read data, valid with done |
| rpl_valid | output | 1 | Reply offered |
| rpl_ready | input | 1 | Reply taken this cycle |
| rpl_src | output | SRC_W | Source address the reply goes back to |
| rpl_port | output | PORT_W | Port the reply concerns |
| rpl_status | output | 2 | 00 acknowledge, 01 busy, 10 error |
| rpl_data | output | DATA_W | Read data, zero otherwise |

## Verification
The assertions assume that a port raises port_done only while its port_req is high. They also assume that the reply sink may hold rpl_ready low for any number of cycles but never drops a reply it has taken. The bench port models pulse done for exactly one cycle, after a random latency, and only during an open request. Command fields are held unchanged until cmd_ready accepts them. Stalling every port and then releasing them together makes all buffers complete in the same cycle, which exercises the round-robin order and the stall of the reply output.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // operation codes carried in a command
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_RSV  = 2'b11
    } sc_op_e;

    // reply status codes
    typedef enum logic [1:0] {
        ST_ACK  = 2'b00,
        ST_BUSY = 2'b01,
        ST_ERR  = 2'b10
    } sc_status_e;

    // life cycle of one port buffer
    typedef enum logic [1:0] {
        SLOT_IDLE,
        SLOT_ACTIVE,
        SLOT_REPLY
    } slot_state_e;

    function automatic logic op_known(input logic [1:0] op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/sc_cmd_decode.sv
module sc_cmd_decode
    import sc_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 3
) (
    input  logic              fire,
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        op,
    input  logic [NPORT-1:0]  slot_busy,
    output logic [NPORT-1:0]  load,
    output logic              imm_load,
    output logic [1:0]        imm_status
);

    logic port_ok;
    logic op_ok;
    logic tgt_busy;
    logic accept;

    always_comb begin
        port_ok  = int'(port) < NPORT;
        op_ok    = op_known(op);
        tgt_busy = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (int'(port) == i) tgt_busy = slot_busy[i];
        end
        accept     = port_ok && op_ok && !tgt_busy;
        imm_load   = fire && !accept;
        imm_status = (port_ok && op_ok) ? ST_BUSY : ST_ERR;
        for (int i = 0; i < NPORT; i++) begin
            load[i] = fire && accept && (int'(port) == i);
        end
    end

endmodule

// File: rtl/sc_port_slot.sv
module sc_port_slot
    import sc_pkg::*;
#(
    parameter int SRC_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SRC_W-1:0]  ld_src,
    input  logic [1:0]        ld_op,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_wdata,
    input  logic              free_i,
    output logic              busy,
    output logic              rsp_pend,
    output logic [SRC_W-1:0]  rsp_src,
    output logic [DATA_W-1:0] rsp_data,
    output logic              port_req,
    output logic              port_we,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    input  logic              port_done,
    input  logic [DATA_W-1:0] port_rdata
);

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } held_t;

    slot_state_e       state_q;
    held_t             cmd_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            cmd_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                SLOT_IDLE: begin
                    if (load) begin
                        state_q     <= SLOT_ACTIVE;
                        cmd_q.src   <= ld_src;
                        cmd_q.op    <= ld_op;
                        cmd_q.addr  <= ld_addr;
                        cmd_q.wdata <= ld_wdata;
                    end
                end
                SLOT_ACTIVE: begin
                    if (port_done) begin
                        state_q <= SLOT_REPLY;
                        rdata_q <= (cmd_q.op == OP_RD) ? port_rdata : '0;
                    end
                end
                SLOT_REPLY: begin
                    if (free_i) state_q <= SLOT_IDLE;
                end
                default: state_q <= SLOT_IDLE;
            endcase
        end
    end

    assign busy       = state_q != SLOT_IDLE;
    assign rsp_pend   = state_q == SLOT_REPLY;
    assign port_req   = state_q == SLOT_ACTIVE;
    assign port_we    = cmd_q.op == OP_WR;
    assign port_addr  = cmd_q.addr;
    assign port_wdata = cmd_q.wdata;
    assign rsp_src    = cmd_q.src;
    assign rsp_data   = rdata_q;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        port_req && !port_done |=> port_req);

    // R3
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

    // R8
    free_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(free_i));

endmodule

// File: rtl/sc_reply_arb.sv
module sc_reply_arb
    import sc_pkg::*;
#(
    parameter int NREQ  = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  req,
    input  logic             take,
    output logic             valid,
    output logic [IDX_W-1:0] grant
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] held_q;
    logic             hold_q;
    logic [IDX_W-1:0] pick;
    logic             found;
    int               j;

    always_comb begin
        pick  = ptr_q;
        found = 1'b0;
        j     = 0;
        for (int k = 0; k < NREQ; k++) begin
            j = int'(ptr_q) + k;
            if (j >= NREQ) j = j - NREQ;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = IDX_W'(j);
            end
        end
    end

    assign valid = |req;
    assign grant = hold_q ? held_q : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            held_q <= '0;
            hold_q <= 1'b0;
        end else begin
            hold_q <= valid && !take;
            held_q <= grant;
            if (valid && take) begin
                ptr_q <= (int'(grant) == NREQ - 1) ? '0 : grant + IDX_W'(1);
            end
        end
    end

    // R6
    grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> req[grant]);

    // R7
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> req[held_q]);

endmodule

// File: rtl/sc_dispatch.sv
module sc_dispatch
    import sc_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 3,
    parameter int SRC_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [SRC_W-1:0]        cmd_src,
    input  logic [PORT_W-1:0]       cmd_port,
    input  logic [1:0]              cmd_op,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [DATA_W-1:0]       cmd_wdata,
    output logic [NPORT-1:0]        port_req,
    output logic [NPORT-1:0]        port_we,
    output logic [NPORT*ADDR_W-1:0] port_addr,
    output logic [NPORT*DATA_W-1:0] port_wdata,
    input  logic [NPORT-1:0]        port_done,
    input  logic [NPORT*DATA_W-1:0] port_rdata,
    output logic                    rpl_valid,
    input  logic                    rpl_ready,
    output logic [SRC_W-1:0]        rpl_src,
    output logic [PORT_W-1:0]       rpl_port,
    output logic [1:0]              rpl_status,
    output logic [DATA_W-1:0]       rpl_data
);

    localparam int NREQ  = NPORT + 1;
    localparam int IDX_W = $clog2(NREQ);
    localparam int IMM   = NPORT;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [PORT_W-1:0] port;
        logic [1:0]        status;
    } imm_t;

    imm_t              imm_q;
    logic              cmd_fire;
    logic [NPORT-1:0]  slot_load;
    logic [NPORT-1:0]  slot_busy;
    logic [NPORT-1:0]  slot_pend;
    logic [NPORT-1:0]  slot_free;
    logic              imm_load;
    logic [1:0]        imm_status;
    logic [SRC_W-1:0]  slot_src  [NPORT];
    logic [DATA_W-1:0] slot_data [NPORT];
    logic [NREQ-1:0]   arb_req;
    logic [IDX_W-1:0]  grant;
    logic              take;

    assign cmd_ready = !imm_q.valid;
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign take      = rpl_valid && rpl_ready;

    sc_cmd_decode #(
        .NPORT (NPORT),
        .PORT_W(PORT_W)
    ) u_dec (
        .fire      (cmd_fire),
        .port      (cmd_port),
        .op        (cmd_op),
        .slot_busy (slot_busy),
        .load      (slot_load),
        .imm_load  (imm_load),
        .imm_status(imm_status)
    );

    // immediate busy / error reply, one deep
    always_ff @(posedge clk) begin
        if (rst) begin
            imm_q <= '0;
        end else if (cmd_fire && imm_load) begin
            imm_q.valid  <= 1'b1;
            imm_q.src    <= cmd_src;
            imm_q.port   <= cmd_port;
            imm_q.status <= imm_status;
        end else if (take && grant == IDX_W'(IMM)) begin
            imm_q.valid <= 1'b0;
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_slot
        assign slot_free[i] = take && (grant == IDX_W'(i));

        sc_port_slot #(
            .SRC_W (SRC_W),
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .load      (slot_load[i]),
            .ld_src    (cmd_src),
            .ld_op     (cmd_op),
            .ld_addr   (cmd_addr),
            .ld_wdata  (cmd_wdata),
            .free_i    (slot_free[i]),
            .busy      (slot_busy[i]),
            .rsp_pend  (slot_pend[i]),
            .rsp_src   (slot_src[i]),
            .rsp_data  (slot_data[i]),
            .port_req  (port_req[i]),
            .port_we   (port_we[i]),
            .port_addr (port_addr[i*ADDR_W +: ADDR_W]),
            .port_wdata(port_wdata[i*DATA_W +: DATA_W]),
            .port_done (port_done[i]),
            .port_rdata(port_rdata[i*DATA_W +: DATA_W])
        );
    end

    assign arb_req = {imm_q.valid, slot_pend};

    sc_reply_arb #(
        .NREQ (NREQ),
        .IDX_W(IDX_W)
    ) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (arb_req),
        .take (take),
        .valid(rpl_valid),
        .grant(grant)
    );

    always_comb begin
        rpl_src    = imm_q.src;
        rpl_port   = imm_q.port;
        rpl_status = imm_q.status;
        rpl_data   = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (grant == IDX_W'(i)) begin
                rpl_src    = slot_src[i];
                rpl_port   = PORT_W'(i);
                rpl_status = ST_ACK;
                rpl_data   = slot_data[i];
            end
        end
    end

    // R7
    rpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rpl_valid && !rpl_ready |=> rpl_valid && $stable(rpl_src) && $stable(rpl_port)
                                    && $stable(rpl_status) && $stable(rpl_data));

    // R4
    bad_cmd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && (int'(cmd_port) >= NPORT || !op_known(cmd_op)) |-> slot_load == '0);

    // R4
    bad_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_fire && (int'(cmd_port) >= NPORT || !op_known(cmd_op))
        |=> imm_q.valid && imm_q.status == ST_ERR);

endmodule

// File: tb/sim_sc_dispatch.sv
module sim_sc_dispatch;
    import sc_pkg::*;

    localparam int NPORT  = 4;
    localparam int PORT_W = 3;
    localparam int SRC_W  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NREQ   = NPORT + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic                    cmd_valid = 1'b0;
    logic                    cmd_ready;
    logic [SRC_W-1:0]        cmd_src   = '0;
    logic [PORT_W-1:0]       cmd_port  = '0;
    logic [1:0]              cmd_op    = '0;
    logic [ADDR_W-1:0]       cmd_addr  = '0;
    logic [DATA_W-1:0]       cmd_wdata = '0;
    logic [NPORT-1:0]        port_req;
    logic [NPORT-1:0]        port_we;
    logic [NPORT*ADDR_W-1:0] port_addr;
    logic [NPORT*DATA_W-1:0] port_wdata;
    logic [NPORT-1:0]        port_done  = '0;
    logic [NPORT*DATA_W-1:0] port_rdata = '0;
    logic                    rpl_valid;
    logic                    rpl_ready = 1'b0;
    logic [SRC_W-1:0]        rpl_src;
    logic [PORT_W-1:0]       rpl_port;
    logic [1:0]              rpl_status;
    logic [DATA_W-1:0]       rpl_data;

    sc_dispatch #(
        .NPORT(NPORT), .PORT_W(PORT_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_port(cmd_port),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .port_req(port_req), .port_we(port_we), .port_addr(port_addr), .port_wdata(port_wdata),
        .port_done(port_done), .port_rdata(port_rdata),
        .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_src(rpl_src), .rpl_port(rpl_port),
        .rpl_status(rpl_status), .rpl_data(rpl_data)
    );

    typedef struct {
        logic [SRC_W-1:0]  src;
        logic [PORT_W-1:0] port;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bcmd_t;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] rfun(input int p, input logic [ADDR_W-1:0] a);
        int v;
        v = (p * 4099) ^ (int'(a) * 37) ^ 'h5a3;
        return DATA_W'(v);
    endfunction

    // reference model state
    int                ms    [NPORT];   // 0 idle, 1 active, 2 reply waiting
    logic [SRC_W-1:0]  msrc  [NPORT];
    logic [1:0]        mop   [NPORT];
    logic [ADDR_W-1:0] maddr [NPORT];
    logic [DATA_W-1:0] mwd   [NPORT];
    logic [DATA_W-1:0] mrd   [NPORT];
    int                mlat  [NPORT];
    bit                mimm = 1'b0;
    logic [SRC_W-1:0]  msrc_i;
    logic [PORT_W-1:0] mport_i;
    logic [1:0]        mst_i;
    int                mptr = 0;
    bit                mhold = 1'b0;
    int                mheld = 0;

    // events decided at the previous falling edge
    bit               ev_cmd = 1'b0;
    bcmd_t            ev_c;
    bit               ev_acc = 1'b0;
    bit               ev_hold = 1'b0;
    int               ev_g = 0;
    logic [NPORT-1:0] ev_done = '0;
    logic [28:0]      prev_fields = '0;

    // stimulus control
    bcmd_t            cq[$];
    bit               run = 1'b0;
    bit               rand_mode = 1'b0;
    int               ready_pct = 100;
    logic [NPORT-1:0] stall = '0;
    int               acc_log[$];
    int               acc_cmds = 0;
    int               replies = 0;
    int               n_busy = 0;
    int               n_busy_rpl = 0;
    int               n_err = 0;

    initial begin
        for (int p = 0; p < NPORT; p++) begin
            ms[p] = 0; mlat[p] = 0; msrc[p] = '0; mop[p] = '0;
            maddr[p] = '0; mwd[p] = '0; mrd[p] = '0;
        end
    end

    function automatic int rr_pick();
        for (int k = 0; k < NREQ; k++) begin
            int j;
            j = (mptr + k) % NREQ;
            if (j == NPORT) begin
                if (mimm) return j;
            end else if (ms[j] == 2) begin
                return j;
            end
        end
        return -1;
    endfunction

    always @(negedge clk) begin
        if (run) begin
            int    g;
            bit    exp_valid;
            string tag;
            // (a) apply the events of the edge just passed
            if (ev_cmd) begin
                int p;
                acc_cmds++;
                p       = int'(ev_c.port);
                msrc_i  = ev_c.src;
                mport_i = ev_c.port;
                if (p >= NPORT || !(ev_c.op == 2'b01 || ev_c.op == 2'b10)) begin
                    mimm = 1'b1; mst_i = 2'b10; n_err++;
                end else if (ms[p] != 0) begin
                    mimm = 1'b1; mst_i = 2'b01; n_busy++;
                    if (ms[p] == 2) n_busy_rpl++;
                end else begin
                    ms[p] = 1; msrc[p] = ev_c.src; mop[p] = ev_c.op;
                    maddr[p] = ev_c.addr; mwd[p] = ev_c.wdata;
                    mlat[p] = int'($urandom_range(0, 6));
                end
            end
            for (int p = 0; p < NPORT; p++) begin
                if (ev_done[p]) begin
                    ms[p]  = 2;
                    mrd[p] = (mop[p] == 2'b01) ? rfun(p, maddr[p]) : '0;
                end
            end
            if (ev_acc) begin
                replies++;
                acc_log.push_back(ev_g);
                if (ev_g == NPORT) mimm = 1'b0; else ms[ev_g] = 0;
                mptr  = (ev_g + 1) % NREQ;
                mhold = 1'b0;
            end else if (ev_hold) begin
                mhold = 1'b1;
                mheld = ev_g;
            end else begin
                mhold = 1'b0;
            end

            // (b) compare outputs with the model
            chk("R9", "cmd_ready", cmd_ready, !mimm);
            for (int p = 0; p < NPORT; p++) begin
                chk("R2", "port_req", port_req[p], ms[p] == 1);
                if (ms[p] == 1) begin
                    chk("R2", "port_we", port_we[p], mop[p] == 2'b10);
                    chk("R2", "port_addr", port_addr[p*ADDR_W +: ADDR_W], maddr[p]);
                    chk("R2", "port_wdata", port_wdata[p*DATA_W +: DATA_W], mwd[p]);
                end
            end
            exp_valid = mimm;
            for (int p = 0; p < NPORT; p++) if (ms[p] == 2) exp_valid = 1'b1;
            chk("R5", "rpl_valid", rpl_valid, exp_valid);
            if (ev_hold) chk("R7", "held reply fields", {rpl_src, rpl_port, rpl_status, rpl_data}, prev_fields);
            g = -1;
            if (rpl_valid && exp_valid) begin
                g = mhold ? mheld : rr_pick();
                if (g == NPORT) begin
                    tag = (mst_i == 2'b10) ? "R4" : "R3/R8";
                    chk(tag, "rpl_status", rpl_status, mst_i);
                    chk(tag, "rpl_port", rpl_port, mport_i);
                    chk("R5", "rpl_src", rpl_src, msrc_i);
                    chk("R10", "rpl_data", rpl_data, 0);
                end else begin
                    chk("R6", "rpl_port", rpl_port, g);
                    chk("R5", "rpl_status", rpl_status, 2'b00);
                    chk("R5", "rpl_src", rpl_src, msrc[g]);
                    chk("R10", "rpl_data", rpl_data, mrd[g]);
                end
            end
            prev_fields = {rpl_src, rpl_port, rpl_status, rpl_data};

            // (c) drive inputs for the next edge
            for (int p = 0; p < NPORT; p++) begin
                ev_done[p] = 1'b0;
                if (ms[p] == 1 && port_req[p]) begin
                    if (mlat[p] == 0 && !stall[p]) ev_done[p] = 1'b1;
                    else if (mlat[p] > 0) mlat[p]--;
                end
                port_rdata[p*DATA_W +: DATA_W] = rfun(p, maddr[p]);
            end
            port_done = ev_done;

            rpl_ready = int'($urandom_range(0, 99)) < ready_pct;
            ev_acc    = rpl_valid && rpl_ready && (g >= 0);
            ev_hold   = rpl_valid && !rpl_ready && (g >= 0);
            ev_g      = g;

            if (rand_mode && cq.size() == 0 && $urandom_range(0, 2) == 0) begin
                bcmd_t c;
                c.src   = SRC_W'($urandom);
                c.port  = ($urandom_range(0, 9) < 8) ? PORT_W'($urandom_range(0, NPORT - 1))
                                                     : PORT_W'($urandom_range(0, 7));
                c.op    = ($urandom_range(0, 9) < 9) ? 2'(1 + $urandom_range(0, 1))
                                                     : (($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11);
                c.addr  = ADDR_W'($urandom);
                c.wdata = DATA_W'($urandom);
                cq.push_back(c);
            end
            ev_cmd = 1'b0;
            if (cq.size() > 0) begin
                cmd_valid = 1'b1;
                cmd_src   = cq[0].src;
                cmd_port  = cq[0].port;
                cmd_op    = cq[0].op;
                cmd_addr  = cq[0].addr;
                cmd_wdata = cq[0].wdata;
                if (cmd_ready) begin
                    ev_cmd = 1'b1;
                    ev_c   = cq[0];
                    void'(cq.pop_front());
                end
            end else begin
                cmd_valid = 1'b0;
            end
        end
    end

    task automatic push(input int src, input int port, input int op, input int addr);
        bcmd_t c;
        c.src = SRC_W'(src); c.port = PORT_W'(port); c.op = 2'(op);
        c.addr = ADDR_W'(addr); c.wdata = DATA_W'(src * 257);
        cq.push_back(c);
    endtask

    function automatic bit all_idle();
        if (mimm || cq.size() != 0) return 1'b0;
        for (int p = 0; p < NPORT; p++) if (ms[p] != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "cmd_ready in reset", cmd_ready, 1);
        chk("R1", "rpl_valid in reset", rpl_valid, 0);
        chk("R1", "port_req in reset", port_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "cmd_ready after reset", cmd_ready, 1);
        chk("R1", "rpl_valid after reset", rpl_valid, 0);
        run = 1'b1;

        // fill every buffer with ports stalled, then hit a busy port and bad commands
        @(posedge clk);
        stall     = '1;
        ready_pct = 100;
        push(8'h11, 0, 1, 8'h10);
        push(8'h12, 1, 2, 8'h20);
        push(8'h13, 2, 1, 8'h30);
        push(8'h14, 3, 2, 8'h40);
        push(8'h15, 2, 1, 8'h31);   // R3 busy
        push(8'h16, 6, 1, 8'h50);   // R4 nonexistent port
        push(8'h17, 1, 3, 8'h60);   // R4 unknown op code
        for (int i = 0; i < 200 && !(cq.size() == 0 && !mimm); i++) @(posedge clk);
        repeat (10) @(posedge clk);
        chk("R3", "busy replies in directed phase", n_busy, 1);
        chk("R4", "error replies in directed phase", n_err, 2);

        // all four ports complete together while the reply sink stalls
        ready_pct = 0;
        stall     = '0;
        repeat (8) @(posedge clk);
        acc_log.delete();
        ready_pct = 100;
        repeat (8) @(posedge clk);
        chk("R6", "directed reply count", acc_log.size(), 4);
        for (int i = 0; i < 4 && i < acc_log.size(); i++) begin
            chk("R6", "directed grant order", acc_log[i], i);
        end

        // random traffic with random latencies and back-pressure
        ready_pct = 70;
        rand_mode = 1'b1;
        repeat (4000) @(posedge clk);
        rand_mode = 1'b0;
        ready_pct = 100;
        for (int i = 0; i < 500 && !all_idle(); i++) @(posedge clk);
        repeat (3) @(posedge clk);
        chk("R5", "one reply per accepted command", replies, acc_cmds);
        chk("R3", "busy replies seen", n_busy > 1, 1);
        chk("R8", "busy while reply waiting seen", n_busy_rpl > 0, 1);
        chk("R4", "error replies seen", n_err > 2, 1);
        finish_run();
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

endmodule